// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a raw window of instruction bytes into the fields that the rest of a simple 64-bit processor needs. Each cycle it receives the program counter, the ten bytes stored at and after that address, and a flag that says whether the memory read failed. The first byte alone sets the instruction class. From it the block derives the operation code, the function code, the two register specifiers, the 64-bit constant, the instruction length, the sequential next address and a status code.

Instructions are between 1 and 10 bytes long. A register specifier of 0xF means "no register". The constant is stored least-significant byte first, and where it starts in the window depends on the class. All outputs are registered with one cycle of latency, which suits a fetch stage that is pipelined in an FPGA fabric.

Top module: `fetch_decode`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take these values after that edge: `icode_o`=1, `ifun_o`=0, `ra_o`=0xF, `rb_o`=0xF, `valc_o`=0, `len_o`=0, `pc_next_o`=0, `stat_o`=1.
- R2: Outputs reflect the inputs sampled at the previous rising edge. `icode_o` is bits 7:4 of byte 0, which is `win_i[7:4]`. `ifun_o` is bits 3:0 of byte 0. Byte k of the window sits at `win_i[8k+7:8k]`.
- R3: The length depends on the class code only. It is 1 for codes 0, 1 and 9, and for codes 0xC–0xF. It is 2 for codes 2, 6, 0xA and 0xB. It is 9 for codes 7 and 8. It is 10 for codes 3, 4 and 5. `pc_next_o` is the sampled PC plus the length, modulo 2^64.
- R4: For codes 2, 4, 5 and 6, `ra_o` is the high nibble of byte 1 and `rb_o` is the low nibble of byte 1. For code 3, `ra_o` is 0xF and `rb_o` is the low nibble of byte 1. For codes 0xA and 0xB, `ra_o` is the high nibble of byte 1 and `rb_o` is 0xF. For all other codes both are 0xF, whatever the other bytes hold.
- R5: For codes 7 and 8, `valc_o` is bytes 1–8 taken little-endian. For codes 3, 4 and 5, it is bytes 2–9 taken little-endian. For all other codes it is zero.
- R6: Status encoding: 1 = normal, 2 = halt, 3 = bad address, 4 = invalid instruction. Byte 0 equal to 0x00 with no memory error gives status 2. A valid instruction of any other kind gives status 1.
- R7: With no memory error, status 4 is produced in two cases. The first is a class code from 0xC to 0xF. The second is a function code above 6 for codes 2 and 7, above 3 for code 6, or nonzero for any other code.
- R8: When `mem_err_i` is high, the status is 3, whatever byte 0 holds. This takes priority over both the invalid-instruction and halt cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 64 | Address of byte 0 of the window |
| win_i | input | 80 | Instruction bytes; byte k in bits 8k+7:8k |
| mem_err_i | input | 1 | The fetch of the window failed |
| icode_o | output | 4 | Class code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier (0xF = none) |
| rb_o | output | 4 | Second register specifier (0xF = none) |
| valc_o | output | 64 | Constant or absolute destination |
| len_o | output | 4 | Instruction length in bytes |
| pc_next_o | output | 64 | Sequential next address |
| stat_o | output | 3 | Status code |

## Verification
The decoder keeps no state between instructions, so a wrong internal decision shows up at the ports exactly one cycle after the window that caused it. A wrong class decision shows as a length or next PC outside the four legal lengths. It can also show as a register field that should read 0xF but does not, or as constant bytes taken from a position one byte off. A wrong status priority shows as a halt or invalid-instruction code in a cycle where the memory error was raised. Each class, each function-code boundary, and the wrap of the next PC are driven with the bytes that would be exposed if the field selection were wrong.

// File: rtl/fd_pkg.sv
package fd_pkg;

  localparam int REG_W = 4;
  localparam logic [REG_W-1:0] REG_NONE = 4'hF;

  typedef enum logic [2:0] {
    ST_OK   = 3'd1,
    ST_HALT = 3'd2,
    ST_ADDR = 3'd3,
    ST_BAD  = 3'd4
  } stat_e;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_BOTH,
    RS_B_ONLY,
    RS_A_ONLY
  } regsel_e;

  typedef enum logic [1:0] {
    CS_NONE,
    CS_AT1,
    CS_AT2
  } constsel_e;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_MOVRR = 4'h2;
  localparam logic [3:0] OP_MOVIR = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

endpackage

// File: rtl/fd_class.sv
module fd_class
  import fd_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int LEN_W      = 4
) (
  input  logic [7:0]       byte0_i,
  output logic [LEN_W-1:0] len_o,
  output regsel_e          regsel_o,
  output constsel_e        constsel_o,
  output logic             legal_o
);

  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO  = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_DEST = LEN_W'(WORD_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(WORD_BYTES + 2);

  logic [3:0] code;
  logic [3:0] fn;
  logic [3:0] fn_max;
  logic       known;

  assign code = byte0_i[7:4];
  assign fn   = byte0_i[3:0];

  always_comb begin
    len_o      = LEN_ONE;
    regsel_o   = RS_NONE;
    constsel_o = CS_NONE;
    fn_max     = 4'd0;
    known      = 1'b1;
    case (code)
      OP_HALT, OP_NOP, OP_RET: begin
        len_o = LEN_ONE;
      end
      OP_MOVRR: begin
        len_o    = LEN_TWO;
        regsel_o = RS_BOTH;
        fn_max   = 4'd6;
      end
      OP_ALU: begin
        len_o    = LEN_TWO;
        regsel_o = RS_BOTH;
        fn_max   = 4'd3;
      end
      OP_PUSH, OP_POP: begin
        len_o    = LEN_TWO;
        regsel_o = RS_A_ONLY;
      end
      OP_MOVIR: begin
        len_o      = LEN_FULL;
        regsel_o   = RS_B_ONLY;
        constsel_o = CS_AT2;
      end
      OP_STORE, OP_LOAD: begin
        len_o      = LEN_FULL;
        regsel_o   = RS_BOTH;
        constsel_o = CS_AT2;
      end
      OP_JUMP: begin
        len_o      = LEN_DEST;
        constsel_o = CS_AT1;
        fn_max     = 4'd6;
      end
      OP_CALL: begin
        len_o      = LEN_DEST;
        constsel_o = CS_AT1;
      end
      default: begin
        known = 1'b0;
      end
    endcase
  end

  assign legal_o = known && (fn <= fn_max);

endmodule

// File: rtl/fd_extract.sv
module fd_extract
  import fd_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int WIN_BYTES  = WORD_BYTES + 2
) (
  input  logic [8*WIN_BYTES-1:0]  win_i,
  input  regsel_e                 regsel_i,
  input  constsel_e               constsel_i,
  output logic [REG_W-1:0]        ra_o,
  output logic [REG_W-1:0]        rb_o,
  output logic [8*WORD_BYTES-1:0] valc_o
);

  logic [7:0] reg_byte;
  assign reg_byte = win_i[15:8];

  always_comb begin
    ra_o = REG_NONE;
    rb_o = REG_NONE;
    case (regsel_i)
      RS_BOTH: begin
        ra_o = reg_byte[7:4];
        rb_o = reg_byte[3:0];
      end
      RS_B_ONLY: rb_o = reg_byte[3:0];
      RS_A_ONLY: ra_o = reg_byte[7:4];
      default: ;
    endcase
  end

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_cbyte
    logic [7:0] lane;
    always_comb begin
      case (constsel_i)
        CS_AT1:  lane = win_i[8*(k+1) +: 8];
        CS_AT2:  lane = win_i[8*(k+2) +: 8];
        default: lane = 8'h00;
      endcase
    end
    assign valc_o[8*k +: 8] = lane;
  end

endmodule

// File: rtl/fd_status.sv
module fd_status
  import fd_pkg::*;
(
  input  logic [7:0] byte0_i,
  input  logic       legal_i,
  input  logic       mem_err_i,
  output stat_e      stat_o
);

  always_comb begin
    if (mem_err_i)
      stat_o = ST_ADDR;
    else if (!legal_i)
      stat_o = ST_BAD;
    else if (byte0_i[7:4] == OP_HALT)
      stat_o = ST_HALT;
    else
      stat_o = ST_OK;
  end

endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
  import fd_pkg::*;
#(
  parameter int PC_W       = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PC_W-1:0]         pc_i,
  input  logic [8*(WORD_BYTES+2)-1:0] win_i,
  input  logic                    mem_err_i,
  output logic [3:0]              icode_o,
  output logic [3:0]              ifun_o,
  output logic [3:0]              ra_o,
  output logic [3:0]              rb_o,
  output logic [8*WORD_BYTES-1:0] valc_o,
  output logic [3:0]              len_o,
  output logic [PC_W-1:0]         pc_next_o,
  output logic [2:0]              stat_o
);

  localparam int WIN_BYTES = WORD_BYTES + 2;
  localparam int LEN_W     = 4;

  logic [LEN_W-1:0]        len_c;
  regsel_e                 regsel_c;
  constsel_e               constsel_c;
  logic                    legal_c;
  logic [REG_W-1:0]        ra_c;
  logic [REG_W-1:0]        rb_c;
  logic [8*WORD_BYTES-1:0] valc_c;
  stat_e                   stat_c;
  logic [PC_W-1:0]         pc_next_c;

  fd_class #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) i_class (
    .byte0_i   (win_i[7:0]),
    .len_o     (len_c),
    .regsel_o  (regsel_c),
    .constsel_o(constsel_c),
    .legal_o   (legal_c)
  );

  fd_extract #(.WORD_BYTES(WORD_BYTES), .WIN_BYTES(WIN_BYTES)) i_extract (
    .win_i     (win_i),
    .regsel_i  (regsel_c),
    .constsel_i(constsel_c),
    .ra_o      (ra_c),
    .rb_o      (rb_c),
    .valc_o    (valc_c)
  );

  fd_status i_status (
    .byte0_i  (win_i[7:0]),
    .legal_i  (legal_c),
    .mem_err_i(mem_err_i),
    .stat_o   (stat_c)
  );

  assign pc_next_c = pc_i + PC_W'(len_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      icode_o   <= OP_NOP;
      ifun_o    <= 4'h0;
      ra_o      <= REG_NONE;
      rb_o      <= REG_NONE;
      valc_o    <= '0;
      len_o     <= '0;
      pc_next_o <= '0;
      stat_o    <= ST_OK;
    end else begin
      icode_o   <= win_i[7:4];
      ifun_o    <= win_i[3:0];
      ra_o      <= ra_c;
      rb_o      <= rb_c;
      valc_o    <= valc_c;
      len_o     <= len_c;
      pc_next_o <= pc_next_c;
      stat_o    <= stat_c;
    end
  end

endmodule

// File: rtl/fetch_decode_chk.sv
module fetch_decode_chk #(
  parameter int PC_W       = 64,
  parameter int WORD_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PC_W-1:0]         pc_i,
  input logic [8*(WORD_BYTES+2)-1:0] win_i,
  input logic                    mem_err_i,
  input logic [3:0]              ra_o,
  input logic [3:0]              rb_o,
  input logic [8*WORD_BYTES-1:0] valc_o,
  input logic [3:0]              len_o,
  input logic [PC_W-1:0]         pc_next_o,
  input logic [2:0]              stat_o
);

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
    live |-> (len_o == 4'd1 || len_o == 4'd2 ||
              len_o == 4'(WORD_BYTES + 1) || len_o == 4'(WORD_BYTES + 2)));

  a_r3_pc_next: assert property (@(posedge clk) disable iff (rst)
    live |-> pc_next_o == $past(pc_i) + PC_W'(len_o));

  a_r4_no_regs_short: assert property (@(posedge clk) disable iff (rst)
    (live && len_o == 4'd1) |-> (ra_o == 4'hF && rb_o == 4'hF));

  a_r5_no_const_short: assert property (@(posedge clk) disable iff (rst)
    (live && len_o <= 4'd2) |-> valc_o == '0);

  a_r6_halt: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(mem_err_i) && $past(win_i[7:0]) == 8'h00) |-> stat_o == 3'd2);

  a_r7_bad_code: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(mem_err_i) && $past(win_i[7:4]) >= 4'hC) |-> stat_o == 3'd4);

  a_r8_addr_first: assert property (@(posedge clk) disable iff (rst)
    (live && $past(mem_err_i)) |-> stat_o == 3'd3);

endmodule

bind fetch_decode fetch_decode_chk #(.PC_W(PC_W), .WORD_BYTES(WORD_BYTES)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .pc_i     (pc_i),
  .win_i    (win_i),
  .mem_err_i(mem_err_i),
  .ra_o     (ra_o),
  .rb_o     (rb_o),
  .valc_o   (valc_o),
  .len_o    (len_o),
  .pc_next_o(pc_next_o),
  .stat_o   (stat_o)
);

// File: tb/test_fetch_decode.sv
`timescale 1ns/1ps
module test_fetch_decode;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pc_i = '0;
  logic [79:0] win_i = '0;
  logic        mem_err_i = 1'b0;
  logic [3:0]  icode_o, ifun_o, ra_o, rb_o, len_o;
  logic [63:0] valc_o, pc_next_o;
  logic [2:0]  stat_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fetch_decode i_fetch_decode (
    .clk(clk), .rst(rst), .pc_i(pc_i), .win_i(win_i), .mem_err_i(mem_err_i),
    .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
    .valc_o(valc_o), .len_o(len_o), .pc_next_o(pc_next_o), .stat_o(stat_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] pc, input logic [79:0] w, input logic err);
    @(negedge clk);
    pc_i = pc; win_i = w; mem_err_i = err;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_all(input string req, input logic [3:0] ic, input logic [3:0] fn,
                            input logic [3:0] a, input logic [3:0] b, input logic [63:0] c,
                            input logic [3:0] l, input logic [63:0] pn, input logic [2:0] st);
    chk(req, "icode", 64'(icode_o), 64'(ic));
    chk(req, "ifun", 64'(ifun_o), 64'(fn));
    chk(req, "ra", 64'(ra_o), 64'(a));
    chk(req, "rb", 64'(rb_o), 64'(b));
    chk(req, "valc", valc_o, c);
    chk(req, "len", 64'(len_o), 64'(l));
    chk(req, "pc_next", pc_next_o, pn);
    chk(req, "stat", 64'(stat_o), 64'(st));
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_all("R1", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 4'd0, 64'h0, 3'd1);
  endtask

  task automatic t_short;
    apply(64'h100, 80'hAAAA_BBBB_CCCC_DDDD_EE00, 1'b0);
    expect_all("R6", 4'h0, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 64'h101, 3'd2);
    apply(64'h200, 80'h1234_5678_9ABC_DEF0_5510, 1'b0);
    expect_all("R4", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 64'h201, 3'd1);
    apply(64'h300, 80'hFFFF_FFFF_FFFF_FFFF_FF90, 1'b0);
    expect_all("R5", 4'h9, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 64'h301, 3'd1);
  endtask

  task automatic t_two_byte;
    apply(64'h10, 80'hFFFF_FFFF_FFFF_FFFF_0660, 1'b0);
    expect_all("R2", 4'h6, 4'h0, 4'h0, 4'h6, 64'h0, 4'd2, 64'h12, 3'd1);
    apply(64'h20, 80'h0000_0000_0000_0000_4320, 1'b0);
    expect_all("R4", 4'h2, 4'h0, 4'h4, 4'h3, 64'h0, 4'd2, 64'h22, 3'd1);
    apply(64'h30, 80'h0000_0000_0000_0000_75A0, 1'b0);
    expect_all("R4", 4'hA, 4'h0, 4'h7, 4'hF, 64'h0, 4'd2, 64'h32, 3'd1);
    apply(64'h40, 80'h0000_0000_0000_0000_3CB0, 1'b0);
    expect_all("R4", 4'hB, 4'h0, 4'h3, 4'hF, 64'h0, 4'd2, 64'h42, 3'd1);
    apply(64'h50, 80'h0000_0000_0000_0000_1226, 1'b0);
    expect_all("R2", 4'h2, 4'h6, 4'h1, 4'h2, 64'h0, 4'd2, 64'h52, 3'd1);
  endtask

  task automatic t_long;
    apply(64'h54, {64'h0000_0000_0000_ABCD, 8'h82, 8'h30}, 1'b0);
    expect_all("R5", 4'h3, 4'h0, 4'hF, 4'h2, 64'hABCD, 4'd10, 64'h5E, 3'd1);
    apply(64'h60, {64'h0000_0000_0000_041C, 8'h64, 8'h40}, 1'b0);
    expect_all("R5", 4'h4, 4'h0, 4'h6, 4'h4, 64'h41C, 4'd10, 64'h6A, 3'd1);
    apply(64'h70, {64'hFFFF_FFFF_FFFF_FFF4, 8'h15, 8'h50}, 1'b0);
    expect_all("R5", 4'h5, 4'h0, 4'h1, 4'h5, 64'hFFFF_FFFF_FFFF_FFF4, 4'd10, 64'h7A, 3'd1);
    apply(64'h7C, {8'hEE, 64'h1122_3344_5566_7788, 8'h73}, 1'b0);
    expect_all("R3", 4'h7, 4'h3, 4'hF, 4'hF, 64'h1122_3344_5566_7788, 4'd9, 64'h85, 3'd1);
    apply(64'h90, {8'hEE, 64'h0000_0000_0000_0123, 8'h80}, 1'b0);
    expect_all("R5", 4'h8, 4'h0, 4'hF, 4'hF, 64'h123, 4'd9, 64'h99, 3'd1);
    apply(64'hFFFF_FFFF_FFFF_FFFA, {64'h0, 8'h0F, 8'h30}, 1'b0);
    expect_all("R3", 4'h3, 4'h0, 4'hF, 4'hF, 64'h0, 4'd10, 64'h4, 3'd1);
  endtask

  task automatic t_invalid;
    apply(64'h400, 80'hFFFF_FFFF_FFFF_FFFF_12C0, 1'b0);
    expect_all("R7", 4'hC, 4'h0, 4'hF, 4'hF, 64'h0, 4'd1, 64'h401, 3'd4);
    apply(64'h410, 80'h0000_0000_0000_0000_00F5, 1'b0);
    chk("R7", "stat code F", 64'(stat_o), 64'd4);
    apply(64'h420, 80'h0000_0000_0000_0000_1227, 1'b0);
    expect_all("R7", 4'h2, 4'h7, 4'h1, 4'h2, 64'h0, 4'd2, 64'h422, 3'd4);
    apply(64'h430, 80'h0000_0000_0000_0000_1264, 1'b0);
    chk("R7", "stat alu fn 4", 64'(stat_o), 64'd4);
    apply(64'h440, 80'h0000_0000_0000_0000_1263, 1'b0);
    chk("R7", "stat alu fn 3", 64'(stat_o), 64'd1);
    apply(64'h450, {8'h0, 64'h5, 8'h77}, 1'b0);
    chk("R7", "stat jump fn 7", 64'(stat_o), 64'd4);
    apply(64'h460, 80'h0000_0000_0000_0000_0011, 1'b0);
    chk("R7", "stat nop fn 1", 64'(stat_o), 64'd4);
    apply(64'h470, 80'h0000_0000_0000_0000_0001, 1'b0);
    chk("R7", "stat halt fn 1", 64'(stat_o), 64'd4);
  endtask

  task automatic t_mem_err;
    apply(64'h500, 80'h0, 1'b1);
    chk("R8", "stat over halt", 64'(stat_o), 64'd3);
    apply(64'h510, 80'h0000_0000_0000_0000_00D0, 1'b1);
    chk("R8", "stat over invalid", 64'(stat_o), 64'd3);
    apply(64'h520, 80'h0000_0000_0000_0000_0660, 1'b1);
    chk("R8", "stat over ok", 64'(stat_o), 64'd3);
    chk("R3", "len under error", 64'(len_o), 64'd2);
    apply(64'h530, 80'h0000_0000_0000_0000_0660, 1'b0);
    chk("R8", "stat clears", 64'(stat_o), 64'd1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    pc_i = 64'h600; win_i = 80'h0000_0000_0000_0000_0010; mem_err_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    pc_i = 64'h700; win_i = 80'h0000_0000_0000_0000_0000;
    #0.5;
    chk("R2", "held until edge", 64'(icode_o), 64'h1);
    @(posedge clk); #1;
    chk("R2", "new after edge", 64'(stat_o), 64'd2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_short();
    t_two_byte();
    t_long();
    t_invalid();
    t_mem_err();
    t_latency();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    expect_all("R1", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 4'd0, 64'h0, 3'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule